// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

One DMA channel that runs transfers described by eight-word descriptors held in memory. Software puts a descriptor address into the channel and rings its doorbell. It then turns the channel on. The engine reads all eight descriptor words over a word-wide memory port. It moves a counted number of fixed-size units from a source address to a target address, and each address can be left fixed or advanced. At the end of the descriptor the engine either follows a link to another descriptor or stops.

A descriptor holds eight 32-bit words at rising addresses: command, source address, target address, count/link, stride difference, request type, and two spare words. The engine uses only the first four and the request type. The link target is an 8-bit offset in the top of the count word. That offset is measured from the start of the 4 KiB block that holds the first descriptor. An interrupt can fire only when a chain ends, so a chain that closes on itself runs until software stops it. A peripheral request input paces the units when the request type is not "auto" (value 8). With "auto", which is used for memory-to-memory copies, units run back to back.

Top module: `lkd_dma_chan`

## Requirements
- R1: After reset, the status, descriptor pointer and count registers read 0, `irq` is low and `mem_req` is low.
- R2: A fetch starts only when three things hold together: the channel's doorbell bit (bit CHAN_ID of register 2) has been set, status bit 0 (enable) is 1, and status bit 30 (eight-word mode) is 1. If enable is set without bit 30, no memory access takes place.
- R3: The engine reads the eight descriptor words from the pointer address upward, one word every 4 bytes. Word 0 is the command, word 1 the source, word 2 the target, word 3 the count/link word and word 5 the request type.
- R4: Command bits 10:8 choose the unit size: 0=4, 1=1, 2=2, 3=16, 4=32, 5=64, 6 or 7=128 bytes. The engine moves count × size bytes, with count taken from bits 23:0 of word 3, in beats of at most one word.
- R5: Command bit 23 advances the source address by each beat's byte count and bit 22 does the same for the target. With a bit cleared, that address stays fixed for the whole descriptor.
- R6: When command bit 0 is set, the engine fetches next the descriptor at (first pointer with bits 11:0 cleared) + 16 × (word 3 bits 31:24) once the current one ends.
- R7: When a descriptor without bit 0 ends, status bit 3 is set and bit 0 is cleared. `irq` then rises only if command bit 1 is set. A chain that links back to itself never raises `irq`.
- R8: A source or target address that is not a multiple of the unit size sets status bits 2 and 4, clears bit 0, moves no data and raises `irq` whatever command bit 1 holds.
- R9: When the request type is not 8, each unit waits for `periph_req` to be high before its first read. Units already started finish normally.
- R10: Register 3 reads the number of units still to move. The value is loaded from the descriptor and drops by one after each unit.
- R11: A status write sets enable and mode from bits 0 and 30, keeps bits 2, 3 and 4 only where the written bit is 1, and clears `irq`. Writing 0 stops a running channel at once.
- R12: For 1- and 2-byte units, each beat's byte lanes come from the address's low two bits. The write enables only the target lanes, and the data is rotated from the source lanes into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 descriptor pointer, 2 doorbell, 3 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables of a write |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the request |
| periph_req | input | 1 | Peripheral ready for one unit |
| irq | output | 1 | Interrupt, held until the next status write |

## Verification
The assertions check the following on every cycle:
- `irq` rises only after a chain end with interrupts enabled, or after an address error.
- The remaining count only falls, except in the cycle a descriptor loads it.
- A paced unit never begins while the request input is low.
- Single-byte writes enable exactly one lane.
- A disabled channel is idle one cycle later.

The bench scenarios cover what depends on memory contents and sequences. These include byte-exact data movement under every increment and lane pattern, link address arithmetic, self-linked looping and the gating of a start. They also cover the rule that an error moves no data.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_WAIT, S_READ, S_WRITE, S_NEXT
  } seq_st_t;

  localparam int CMD_LINK = 0;
  localparam int CMD_TIE  = 1;
  localparam int CMD_DINC = 22;
  localparam int CMD_SINC = 23;
  localparam int TSZ_LSB  = 8;

  localparam int ST_EN  = 0;
  localparam int ST_HLT = 2;
  localparam int ST_TT  = 3;
  localparam int ST_AR  = 4;
  localparam int ST_D8  = 30;

  // unit size code -> bytes
  function automatic logic [7:0] unit_bytes(input logic [2:0] tsz);
    case (tsz)
      3'd0: return 8'd4;
      3'd1: return 8'd1;
      3'd2: return 8'd2;
      3'd3: return 8'd16;
      3'd4: return 8'd32;
      3'd5: return 8'd64;
      default: return 8'd128;
    endcase
  endfunction

  // bytes moved by one memory beat
  function automatic logic [2:0] beat_bytes(input logic [7:0] ub);
    return (ub < 8'd4) ? ub[2:0] : 3'd4;
  endfunction

  function automatic logic [5:0] beats_per_unit(input logic [7:0] ub);
    return (ub < 8'd4) ? 6'd1 : 6'(ub >> 2);
  endfunction

  function automatic logic misaligned(input logic [31:0] a, input logic [7:0] ub);
    return |(a[7:0] & (ub - 8'd1));
  endfunction

endpackage

// File: rtl/lkd_dma_regs.sv
module lkd_dma_regs
  import lkd_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int CHAN_ID = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             seq_idle,
  input  logic             done_evt,
  input  logic             done_tie,
  input  logic             err_evt,
  input  logic [CNT_W-1:0] cnt_cur,
  output logic             start,
  output logic             enable,
  output logic [31:0]      desc_ptr,
  output logic             irq
);

  logic en_q, d8_q, hlt_q, tt_q, ar_q, pend_q, irq_q;
  logic [31:0] dptr_q;

  assign start    = en_q && d8_q && pend_q && !hlt_q && !ar_q && seq_idle;
  assign enable   = en_q;
  assign desc_ptr = dptr_q;
  assign irq      = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; d8_q <= 1'b0; hlt_q <= 1'b0; tt_q <= 1'b0; ar_q <= 1'b0;
      pend_q <= 1'b0; irq_q <= 1'b0; dptr_q <= '0;
    end else begin
      if (start) pend_q <= 1'b0;
      if (done_evt) begin
        en_q <= 1'b0;
        tt_q <= 1'b1;
        if (done_tie) irq_q <= 1'b1;
      end
      if (err_evt) begin
        en_q <= 1'b0; hlt_q <= 1'b1; ar_q <= 1'b1; irq_q <= 1'b1;
      end
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin
            en_q  <= reg_wdata[ST_EN];
            d8_q  <= reg_wdata[ST_D8];
            hlt_q <= hlt_q & reg_wdata[ST_HLT];
            tt_q  <= tt_q & reg_wdata[ST_TT];
            ar_q  <= ar_q & reg_wdata[ST_AR];
            irq_q <= 1'b0;
          end
          2'd1: dptr_q <= reg_wdata;
          2'd2: if (reg_wdata[CHAN_ID]) pend_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[ST_EN]  = en_q;
        reg_rdata[ST_HLT] = hlt_q;
        reg_rdata[ST_TT]  = tt_q;
        reg_rdata[ST_AR]  = ar_q;
        reg_rdata[ST_D8]  = d8_q;
      end
      2'd1: reg_rdata = dptr_q;
      2'd3: reg_rdata[CNT_W-1:0] = cnt_cur;
      default: ;
    endcase
  end

  // R7 R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(err_evt || (done_evt && done_tie)));

endmodule

// File: rtl/lkd_dma_lane.sv
module lkd_dma_lane (
  input  logic [31:0] rd_word,
  input  logic [1:0]  src_lane,
  input  logic [1:0]  dst_lane,
  input  logic [2:0]  nbytes,
  output logic [31:0] wr_word,
  output logic [3:0]  be
);

  logic [1:0]  rot;
  logic [63:0] dbl;
  logic [7:0]  mask;

  always_comb begin
    rot     = dst_lane - src_lane;
    dbl     = {rd_word, rd_word} << {rot, 3'b000};
    wr_word = dbl[63:32];
    mask    = ((8'd1 << nbytes) - 8'd1) << dst_lane;
    be      = mask[3:0];
  end

endmodule

// File: rtl/lkd_dma_seq.sv
module lkd_dma_seq
  import lkd_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int OFF_W    = 8,
  parameter int AUTO_REQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enable,
  input  logic [31:0]      desc_ptr,
  input  logic             periph_req,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             seq_idle,
  output logic             done_evt,
  output logic             done_tie,
  output logic             err_evt,
  output logic [CNT_W-1:0] cnt_cur,
  output logic [1:0]       src_lane,
  output logic [1:0]       dst_lane,
  output logic [2:0]       beat_n,
  output logic [2:0]       unit_tsz,
  output logic [31:0]      data_q
);

  localparam int BLK_LSB = OFF_W + 4;

  seq_st_t st;
  logic [2:0]          fidx;
  logic [31:0]         cur_desc, src_a, dst_a, rtype;
  logic [31:BLK_LSB]   blk;
  logic [OFF_W-1:0]    nxt_off;
  logic [CNT_W-1:0]    cnt_q;
  logic [5:0]          beat_q;
  logic                c_link, c_tie, c_sinc, c_dinc;
  logic [2:0]          c_tsz;

  logic [7:0] ub;
  logic [2:0] bb;
  logic [5:0] nbeats;
  logic       last_beat, is_auto, bad_addr, load_evt;

  assign ub        = unit_bytes(c_tsz);
  assign bb        = beat_bytes(ub);
  assign nbeats    = beats_per_unit(ub);
  assign last_beat = (beat_q == nbeats - 6'd1);
  assign is_auto   = (rtype == 32'(AUTO_REQ));
  assign bad_addr  = misaligned(src_a, ub) || misaligned(dst_a, ub);
  assign load_evt  = (st == S_FETCH) && mem_ack && (fidx == 3'd3);

  assign err_evt   = (st == S_CHECK) && bad_addr;
  assign done_evt  = (st == S_NEXT) && !c_link;
  assign done_tie  = c_tie;
  assign seq_idle  = (st == S_IDLE);
  assign cnt_cur   = cnt_q;
  assign src_lane  = src_a[1:0];
  assign dst_lane  = dst_a[1:0];
  assign beat_n    = bb;
  assign unit_tsz  = c_tsz;

  assign mem_req = (st == S_FETCH) || (st == S_READ) || (st == S_WRITE);
  assign mem_we  = (st == S_WRITE);

  always_comb begin
    case (st)
      S_FETCH: mem_addr = cur_desc + {27'd0, fidx, 2'b00};
      S_READ:  mem_addr = {src_a[31:2], 2'b00};
      S_WRITE: mem_addr = {dst_a[31:2], 2'b00};
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fidx <= '0; cur_desc <= '0; src_a <= '0; dst_a <= '0;
      rtype <= '0; blk <= '0; nxt_off <= '0; cnt_q <= '0; beat_q <= '0;
      c_link <= 1'b0; c_tie <= 1'b0; c_sinc <= 1'b0; c_dinc <= 1'b0;
      c_tsz <= '0; data_q <= '0;
    end else if (!enable && st != S_IDLE) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_FETCH;
          fidx     <= '0;
          cur_desc <= desc_ptr;
          blk      <= desc_ptr[31:BLK_LSB];
        end
        S_FETCH: if (mem_ack) begin
          case (fidx)
            3'd0: begin
              c_link <= mem_rdata[CMD_LINK];
              c_tie  <= mem_rdata[CMD_TIE];
              c_sinc <= mem_rdata[CMD_SINC];
              c_dinc <= mem_rdata[CMD_DINC];
              c_tsz  <= mem_rdata[TSZ_LSB +: 3];
            end
            3'd1: src_a <= mem_rdata;
            3'd2: dst_a <= mem_rdata;
            3'd3: begin
              cnt_q   <= mem_rdata[CNT_W-1:0];
              nxt_off <= mem_rdata[31 -: OFF_W];
            end
            3'd5: rtype <= mem_rdata;
            default: ;
          endcase
          fidx <= fidx + 3'd1;
          if (fidx == 3'd7) st <= S_CHECK;
        end
        S_CHECK: begin
          beat_q <= '0;
          if (bad_addr)          st <= S_IDLE;
          else if (cnt_q == '0)  st <= S_NEXT;
          else                   st <= S_WAIT;
        end
        S_WAIT: if (is_auto || periph_req) st <= S_READ;
        S_READ: if (mem_ack) begin
          data_q <= mem_rdata;
          st     <= S_WRITE;
        end
        S_WRITE: if (mem_ack) begin
          if (c_sinc) src_a <= src_a + 32'(bb);
          if (c_dinc) dst_a <= dst_a + 32'(bb);
          if (last_beat) begin
            beat_q <= '0;
            cnt_q  <= cnt_q - 1'b1;
            st     <= (cnt_q == CNT_W'(1)) ? S_NEXT : S_WAIT;
          end else begin
            beat_q <= beat_q + 6'd1;
            st     <= S_READ;
          end
        end
        S_NEXT: begin
          if (c_link) begin
            cur_desc <= {blk, nxt_off, 4'b0000};
            fidx     <= '0;
            st       <= S_FETCH;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_evt) |-> cnt_q <= $past(cnt_q));

  // R9
  req_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && $past(st) == S_WAIT && !is_auto) |-> $past(periph_req));

endmodule

// File: rtl/lkd_dma_chan.sv
module lkd_dma_chan
  import lkd_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int OFF_W    = 8,
  parameter int CHAN_ID  = 3,
  parameter int AUTO_REQ = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        periph_req,
  output logic        irq
);

  logic             seq_idle, done_evt, done_tie, err_evt, start, enable;
  logic [31:0]      desc_ptr, data_q;
  logic [CNT_W-1:0] cnt_cur;
  logic [1:0]       src_lane, dst_lane;
  logic [2:0]       beat_n, unit_tsz;

  lkd_dma_regs #(.CNT_W(CNT_W), .CHAN_ID(CHAN_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_idle(seq_idle),
    .done_evt(done_evt), .done_tie(done_tie), .err_evt(err_evt),
    .cnt_cur(cnt_cur), .start(start), .enable(enable),
    .desc_ptr(desc_ptr), .irq(irq)
  );

  lkd_dma_seq #(.CNT_W(CNT_W), .OFF_W(OFF_W), .AUTO_REQ(AUTO_REQ)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
    .desc_ptr(desc_ptr), .periph_req(periph_req), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .seq_idle(seq_idle), .done_evt(done_evt),
    .done_tie(done_tie), .err_evt(err_evt), .cnt_cur(cnt_cur),
    .src_lane(src_lane), .dst_lane(dst_lane), .beat_n(beat_n),
    .unit_tsz(unit_tsz), .data_q(data_q)
  );

  lkd_dma_lane u_lane (
    .rd_word(data_q), .src_lane(src_lane), .dst_lane(dst_lane),
    .nbytes(beat_n), .wr_word(mem_wdata), .be(mem_be)
  );

  // R11
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> seq_idle);

  // R12
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && unit_tsz == 3'd1) |-> $onehot(mem_be));

endmodule

// File: tb/sim_lkd_dma_chan.sv
module sim_lkd_dma_chan;
  localparam int CLK_PERIOD = 10;
  localparam int CHAN = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata;
  logic        mem_ack;
  logic        periph_req = 1'b0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  lkd_dma_chan #(.CHAN_ID(CHAN)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .periph_req(periph_req), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int wr_seen = 0, rd_seen = 0;
  bit sb_on = 1'b1;
  bit finished = 1'b0;
  string cur_tag = "R4";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model: 4 KiB, ack one cycle after request
  logic [31:0] mem [0:1023];

  function automatic logic [7:0] pb(input int a);
    return 8'(a ^ (a >> 5) ^ 8'h3C);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we)
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[11:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
      end
    end
  end

  // scoreboard
  typedef struct packed {
    logic [31:0] a;
    logic [3:0]  be;
    logic [31:0] d;
  } wr_t;
  wr_t exp_q[$];

  always @(negedge clk) begin
    if (rst_n && mem_req && !mem_ack) begin
      if (mem_we) begin
        wr_seen++;
        if (sb_on) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, {cur_tag, " unexpected write"}, mem_addr, 32'hFFFF_FFFF);
          end else begin
            wr_t e;
            logic [31:0] m;
            e = exp_q.pop_front();
            m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
            chk(mem_addr == e.a, {cur_tag, " write address"}, mem_addr, e.a);
            chk(mem_be == e.be, {cur_tag, " byte enables"}, {28'd0, mem_be}, {28'd0, e.be});
            chk((mem_wdata & m) == (e.d & m), {cur_tag, " write data"},
                mem_wdata & m, e.d & m);
          end
        end
      end else begin
        rd_seen++;
      end
    end
  end

  // driver: expected writes of one descriptor
  task automatic expect_copy(input int src, input int dst, input int ub,
                             input int n, input bit sinc, input bit dinc);
    int bb, nb, s, d;
    bb = (ub < 4) ? ub : 4;
    nb = (ub < 4) ? 1 : ub / 4;
    s = src; d = dst;
    for (int u = 0; u < n; u++) begin
      for (int b = 0; b < nb; b++) begin
        wr_t e;
        e.a = 32'(d & ~3); e.be = '0; e.d = '0;
        for (int k = 0; k < bb; k++) begin
          int ln;
          ln = (d & 3) + k;
          e.d[ln*8 +: 8] = pb(s + k);
          e.be[ln] = 1'b1;
        end
        exp_q.push_back(e);
        if (sinc) s += bb;
        if (dinc) d += bb;
      end
    end
  endtask

  function automatic logic [31:0] mk_cmd(input bit link, input bit tie,
      input int tsz, input bit sinc, input bit dinc);
    return 32'(link) | (32'(tie) << 1) | (32'(tsz) << 8) |
           (32'(dinc) << 22) | (32'(sinc) << 23);
  endfunction

  task automatic put_desc(input int at, input logic [31:0] cmd, input int src,
      input int dst, input int cnt, input int off, input int rtype);
    mem[at/4 + 0] = cmd;
    mem[at/4 + 1] = 32'(src);
    mem[at/4 + 2] = 32'(dst);
    mem[at/4 + 3] = (32'(off) << 24) | 32'(cnt);
    mem[at/4 + 4] = 32'd0;
    mem[at/4 + 5] = 32'(rtype);
    mem[at/4 + 6] = 32'd0;
    mem[at/4 + 7] = 32'd0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic launch(input int dptr);
    reg_write(2'd1, 32'(dptr));
    reg_write(2'd2, 32'd1 << CHAN);
    reg_write(2'd0, 32'h4000_0001);
  endtask

  task automatic wait_stop();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_read(2'd0, s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < 1024; i++)
      mem[i] = {pb(4*i+3), pb(4*i+2), pb(4*i+1), pb(4*i)};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, v); chk(v == 0, "R1 status", v, 0);
    reg_read(2'd1, v); chk(v == 0, "R1 pointer", v, 0);
    reg_read(2'd3, v); chk(v == 0, "R1 count", v, 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);

    // R2 no eight-word mode: no fetch
    put_desc(32'h100, mk_cmd(0,1,0,1,1), 32'hC00, 32'h800, 4, 0, 8);
    reg_write(2'd1, 32'h100);
    reg_write(2'd2, 32'd1 << CHAN);
    reg_write(2'd0, 32'h0000_0001);
    repeat (20) @(negedge clk);
    chk(rd_seen == 0, "R2 gated start", rd_seen, 0);
    reg_write(2'd0, 32'h0);

    // R3 R4 R7 word copy with interrupt
    cur_tag = "R4";
    expect_copy(32'hC00, 32'h800, 4, 4, 1, 1);
    launch(32'h100);
    wait_stop();
    chk(exp_q.size() == 0, "R4 all words moved", exp_q.size(), 0);
    reg_read(2'd0, v); chk(v == 32'h4000_0008, "R7 status after end", v, 32'h4000_0008);
    chk(irq == 1, "R7 irq with TIE", 32'(irq), 1);
    reg_read(2'd3, v); chk(v == 0, "R10 count at end", v, 0);
    reg_write(2'd0, 32'h0);
    reg_read(2'd0, v); chk(v == 0, "R11 status cleared", v, 0);
    chk(irq == 0, "R11 irq cleared", 32'(irq), 0);

    // R12 byte units with lane rotation
    cur_tag = "R12";
    put_desc(32'h140, mk_cmd(0,1,1,1,1), 32'hC01, 32'h902, 3, 0, 8);
    expect_copy(32'hC01, 32'h902, 1, 3, 1, 1);
    launch(32'h140);
    wait_stop();
    chk(exp_q.size() == 0, "R12 all bytes moved", exp_q.size(), 0);

    // R5 R6 two-descriptor chain, fixed target then fixed source
    cur_tag = "R5";
    put_desc(32'h200, mk_cmd(1,0,3,1,0), 32'hC40, 32'hA00, 2, 8'h30, 8);
    put_desc(32'h300, mk_cmd(0,1,0,0,1), 32'hC80, 32'hA40, 2, 0, 8);
    expect_copy(32'hC40, 32'hA00, 16, 2, 1, 0);
    expect_copy(32'hC80, 32'hA40, 4, 2, 0, 1);
    launch(32'h200);
    wait_stop();
    chk(exp_q.size() == 0, "R6 linked descriptor ran", exp_q.size(), 0);
    chk(irq == 1, "R7 irq at chain end", 32'(irq), 1);

    // R7 no TIE: terminated but no interrupt
    cur_tag = "R4";
    put_desc(32'h380, mk_cmd(0,0,2,1,1), 32'hC02, 32'hB00, 2, 0, 8);
    expect_copy(32'hC02, 32'hB00, 2, 2, 1, 1);
    launch(32'h380);
    wait_stop();
    reg_read(2'd0, v); chk(v == 32'h4000_0008, "R7 status no TIE", v, 32'h4000_0008);
    chk(irq == 0, "R7 no irq without TIE", 32'(irq), 0);

    // R8 misaligned source
    put_desc(32'h600, mk_cmd(0,0,0,1,1), 32'hC02, 32'hB40, 2, 0, 8);
    base = wr_seen;
    launch(32'h600);
    wait_stop();
    reg_read(2'd0, v); chk(v == 32'h4000_0014, "R8 error status", v, 32'h4000_0014);
    chk(irq == 1, "R8 irq without TIE", 32'(irq), 1);
    chk(wr_seen == base, "R8 no data moved", wr_seen, base);
    reg_write(2'd0, 32'h0);
    reg_read(2'd0, v); chk(v == 0, "R11 error cleared", v, 0);

    // R9 R10 paced by peripheral request
    cur_tag = "R9";
    put_desc(32'h700, mk_cmd(0,1,0,1,1), 32'hC10, 32'hB80, 3, 0, 1);
    expect_copy(32'hC10, 32'hB80, 4, 3, 1, 1);
    base = wr_seen;
    launch(32'h700);
    repeat (60) @(negedge clk);
    chk(wr_seen == base, "R9 holds without request", wr_seen, base);
    reg_read(2'd3, v); chk(v == 3, "R10 count loaded", v, 3);
    periph_req = 1'b1;
    for (int i = 0; i < 200 && wr_seen == base; i++) @(negedge clk);
    periph_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(wr_seen == base + 1, "R9 one unit per request", wr_seen, base + 1);
    reg_read(2'd3, v); chk(v == 2, "R10 count after one unit", v, 2);
    periph_req = 1'b1;
    wait_stop();
    periph_req = 1'b0;
    chk(exp_q.size() == 0, "R9 remaining units moved", exp_q.size(), 0);

    // R6 R7 R11 self-linked loop, then stop
    sb_on = 1'b0;
    put_desc(32'h500, mk_cmd(1,1,0,1,1), 32'hC20, 32'hBC0, 1, 8'h50, 8);
    base = wr_seen;
    launch(32'h500);
    repeat (300) @(negedge clk);
    chk(irq == 0, "R7 loop never interrupts", 32'(irq), 0);
    chk(wr_seen >= base + 3, "R6 loop keeps running", wr_seen, base + 3);
    reg_read(2'd0, v); chk(v == 32'h4000_0001, "R7 loop still enabled", v, 32'h4000_0001);
    reg_write(2'd0, 32'h0);
    repeat (3) @(negedge clk);
    chk(mem_req == 0, "R11 stop halts memory", 32'(mem_req), 0);
    reg_read(2'd0, v); chk(v == 0, "R11 status after stop", v, 0);
    sb_on = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule